// File: doc/BRIEF.md
# Serial NOR Flash Read Sequencer

This block runs one read transaction against a serial NOR flash through a four-wire serial master port. A request carries a byte offset into the flash, a byte count and a mode flag. On an accepted request the block pulls chip select low and sends a read header on the single output data line. It then clocks in the requested number of data bytes, presents each one on a byte output with a one-cycle strobe, and releases chip select.

Two read forms are supported. The plain form sends opcode 0x03 and the address and then receives one bit per serial clock on the input line. The dual-output form sends opcode 0x3B, the address and one 0x00 dummy byte, all on the single output line. It then turns that line around and receives two bits per serial clock on both data lines. The serial clock idles low, the flash samples on the rising edge, and the block samples returned data on the rising edge as well. The serial clock runs at the system clock divided by twice `HALF_DIV`.

Top module: `spi_flash_reader`

## Requirements
- R1: In plain mode, after chip select falls, `spi_io0_out` carries the 8-bit opcode 0x03 and then the address, 32 bits in all, one bit per rising edge of `spi_sclk`. `spi_sclk` idles low and `spi_io0_oe` stays high throughout the header.
- R2: In dual mode, `spi_io0_out` carries opcode 0x3B, then the address, then one dummy byte of value 0x00, 40 bits in all, with `spi_io0_oe` high for every one of them.
- R3: The address is sent most significant bit first, starting at bit 23 and ending at bit 0.
- R4: In the dual data phase `spi_io0_oe` is low. Each rising edge of `spi_sclk` captures two bits, `spi_io1_in` as the higher and `spi_io0_in` as the lower bit of the pair. The first pair forms bits 7:6, so each byte takes four serial clocks.
- R5: In the plain data phase each rising edge of `spi_sclk` captures one bit from `spi_io1_in`, most significant bit first, so each byte takes eight serial clocks.
- R6: `rd_valid` is a one-cycle pulse for each received byte with the byte on `rd_data`. A transaction delivers exactly `byte_count` bytes, in the order the flash returned them.
- R7: Chip select falls once per transaction and stays low from before the first serial clock edge until after the last data bit. `spi_sclk` is low whenever `spi_cs_n` is high.
- R8: `busy` is high from the cycle after an accepted `start` until chip select is released. `done` pulses for one cycle in the same cycle that `spi_cs_n` returns high and `busy` falls.
- R9: A `start` with `byte_count` of zero raises `done` in the next cycle. It never lowers chip select and never raises `busy`.
- R10: A `start` that arrives while `busy` is high is ignored: the running transaction keeps its address, mode and byte count.
- R11: Every high phase of `spi_sclk` lasts exactly `HALF_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken when not busy |
| dual_mode | input | 1 | 1 selects the dual-output read, 0 the plain read |
| addr | input | ADDR_W | Flash byte offset |
| byte_count | input | CNT_W | Number of data bytes to read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | Strobe for `rd_data` |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_io0_out | output | 1 | Output data line, header bits |
| spi_io0_oe | output | 1 | Drive enable for the output data line |
| spi_io0_in | input | 1 | Lower data bit in the dual data phase |
| spi_io1_in | input | 1 | Data input in plain mode, upper bit in dual mode |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 16-bit count, one dummy byte and `HALF_DIV` of 2. With these settings a full dual read of several bytes finishes in a few hundred cycles, so every byte count from zero to five can be swept in both modes. The sweep also covers an offset close to the top of the address space, where the flash model's returned data crosses the wrap, and an offset whose address bits alternate. A behavioural flash in the bench decodes the header and serves bytes that it computes from the decoded address. It also flags any serial clock edge outside chip select and any output-enable error in either phase.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_DATA = 2'd2,
      ST_TAIL = 2'd3
   } fsr_state_e;

   localparam logic [7:0] OPC_PLAIN_READ = 8'h03;
   localparam logic [7:0] OPC_DUAL_READ  = 8'h3B;

endpackage

// File: rtl/fsr_sclk_gen.sv
module fsr_sclk_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic park_i,
   output logic sclk_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic tick;
   logic ph_q;

   generate
      if (HALF_DIV == 1) begin : g_full_rate
         assign tick = run_i;
      end else begin : g_divided
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(HALF_DIV - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick = run_i && (cnt_q == CW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= 1'b0;
         sclk_o <= 1'b0;
      end else if (!run_i) begin
         ph_q   <= 1'b0;
         sclk_o <= 1'b0;
      end else if (tick) begin
         ph_q   <= ~ph_q;
         sclk_o <= ~ph_q && !park_i;
      end
   end

   assign rise_o = tick && !ph_q;
   assign fall_o = tick && ph_q;

endmodule

// File: rtl/fsr_hdr_tx.sv
module fsr_hdr_tx #(
   parameter int ADDR_W      = 24,
   parameter int DUMMY_BYTES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [7:0]        opcode_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              mosi_o
);

   localparam int HDR_W = 8 + ADDR_W + 8 * DUMMY_BYTES;
   localparam int CMD_W = 8 + ADDR_W;

   logic [HDR_W-1:0] sr_q;
   logic [HDR_W-1:0] load_val;

   always_comb begin
      load_val = '0;
      load_val[HDR_W-1 -: CMD_W] = {opcode_i, addr_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= load_val;
      end else if (shift_i) begin
         sr_q <= {sr_q[HDR_W-2:0], 1'b0};
      end
   end

   assign mosi_o = sr_q[HDR_W-1];

endmodule

// File: rtl/fsr_rx_byte.sv
module fsr_rx_byte (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       sample_i,
   input  logic       dual_i,
   input  logic       io0_i,
   input  logic       io1_i,
   output logic       byte_done_o,
   output logic [7:0] data_o,
   output logic       valid_o
);

   logic [7:0] sr_q;
   logic [7:0] sr_next;
   logic [2:0] cnt_q;
   logic [2:0] cnt_last;

   assign cnt_last    = dual_i ? 3'd3 : 3'd7;
   assign sr_next     = dual_i ? {sr_q[5:0], io1_i, io0_i} : {sr_q[6:0], io1_i};
   assign byte_done_o = sample_i && (cnt_q == cnt_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '0;
         cnt_q   <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (clr_i) begin
            cnt_q <= '0;
         end else if (sample_i) begin
            sr_q <= sr_next;
            if (cnt_q == cnt_last) begin
               cnt_q   <= '0;
               data_o  <= sr_next;
               valid_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader #(
   parameter int         ADDR_W      = 24,
   parameter int         CNT_W       = 16,
   parameter int         HALF_DIV    = 2,
   parameter int         DUMMY_BYTES = 1,
   parameter logic [7:0] OPC_PLAIN   = fsr_pkg::OPC_PLAIN_READ,
   parameter logic [7:0] OPC_DUAL    = fsr_pkg::OPC_DUAL_READ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dual_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  byte_count,
   output logic              busy,
   output logic              done,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_io0_out,
   output logic              spi_io0_oe,
   input  logic              spi_io0_in,
   input  logic              spi_io1_in
);

   import fsr_pkg::*;

   localparam int SNG_W = 8 + ADDR_W;
   localparam int HDR_W = SNG_W + 8 * DUMMY_BYTES;
   localparam int HC_W  = $clog2(HDR_W + 1);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if ((ADDR_W % 8) != 0 || ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be a positive multiple of 8");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (DUMMY_BYTES < 0) begin : g_bad_dummy
         $error("DUMMY_BYTES must not be negative");
      end
   endgenerate

   fsr_state_e       state_q;
   logic             dual_q;
   logic [CNT_W-1:0] bytes_left_q;
   logic [HC_W-1:0]  hdr_cnt_q;
   logic [HC_W-1:0]  hdr_last;
   logic             accept;
   logic             sck_rise;
   logic             sck_fall;
   logic             byte_done;

   assign accept   = (state_q == ST_IDLE) && start && (byte_count != '0);
   assign hdr_last = dual_q ? HC_W'(HDR_W - 1) : HC_W'(SNG_W - 1);
   assign busy     = (state_q != ST_IDLE);

   fsr_sclk_gen #(
      .HALF_DIV (HALF_DIV)
   ) u_sclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q != ST_IDLE),
      .park_i (state_q == ST_TAIL),
      .sclk_o (spi_sclk),
      .rise_o (sck_rise),
      .fall_o (sck_fall)
   );

   fsr_hdr_tx #(
      .ADDR_W      (ADDR_W),
      .DUMMY_BYTES (DUMMY_BYTES)
   ) u_hdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .shift_i  (sck_fall && (state_q == ST_HDR)),
      .opcode_i (dual_mode ? OPC_DUAL : OPC_PLAIN),
      .addr_i   (addr),
      .mosi_o   (spi_io0_out)
   );

   fsr_rx_byte u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (state_q == ST_HDR),
      .sample_i    (sck_rise && (state_q == ST_DATA)),
      .dual_i      (dual_q),
      .io0_i       (spi_io0_in),
      .io1_i       (spi_io1_in),
      .byte_done_o (byte_done),
      .data_o      (rd_data),
      .valid_o     (rd_valid)
   );

   assign spi_io0_oe = !(dual_q && ((state_q == ST_DATA) || (state_q == ST_TAIL)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         dual_q       <= 1'b0;
         bytes_left_q <= '0;
         hdr_cnt_q    <= '0;
         spi_cs_n     <= 1'b1;
         done         <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start && (byte_count == '0)) begin
                  done <= 1'b1;
               end else if (accept) begin
                  state_q      <= ST_HDR;
                  dual_q       <= dual_mode;
                  bytes_left_q <= byte_count;
                  hdr_cnt_q    <= '0;
                  spi_cs_n     <= 1'b0;
               end
            end
            ST_HDR: begin
               if (sck_fall) begin
                  hdr_cnt_q <= hdr_cnt_q + 1'b1;
                  if (hdr_cnt_q == hdr_last) begin
                     state_q <= ST_DATA;
                  end
               end
            end
            ST_DATA: begin
               if (byte_done) begin
                  bytes_left_q <= bytes_left_q - 1'b1;
               end
               if (sck_fall && (bytes_left_q == '0)) begin
                  state_q <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (sck_rise) begin
                  spi_cs_n <= 1'b1;
                  done     <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fsr_read_seq_chk.sv
module fsr_read_seq_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] byte_count,
   input logic             busy,
   input logic             done,
   input logic             rd_valid,
   input logic             spi_cs_n,
   input logic             spi_sclk
);

   AST_BUSY_HOLDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !spi_cs_n) else $error("busy without chip select"); // R7

   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk) else $error("serial clock high while deselected"); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R8

   AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && !busy)) else $error("done before release"); // R8

   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (byte_count == '0)) |=> (done && spi_cs_n)) else $error("zero count not immediate"); // R9

   AST_VALID_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy) else $error("byte strobe outside transaction"); // R6

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid) else $error("byte strobe stuck"); // R6

endmodule

bind spi_flash_reader fsr_read_seq_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .byte_count (byte_count),
   .busy       (busy),
   .done       (done),
   .rd_valid   (rd_valid),
   .spi_cs_n   (spi_cs_n),
   .spi_sclk   (spi_sclk)
);

// File: tb/spi_flash_reader_tb.sv
`timescale 1ns/1ps
module spi_flash_reader_tb;

   localparam int ADDR_W = 24;
   localparam int CNT_W  = 16;
   localparam int HALF   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              dual_mode = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [CNT_W-1:0]  byte_count = '0;
   logic              busy, done, rd_valid, spi_cs_n, spi_sclk, spi_io0_out, spi_io0_oe;
   logic [7:0]        rd_data;
   logic              m_io0 = 1'b0;
   logic              m_io1 = 1'b0;

   always #2 clk = ~clk;

   spi_flash_reader #(
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .HALF_DIV (HALF)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .dual_mode   (dual_mode),
      .addr        (addr),
      .byte_count  (byte_count),
      .busy        (busy),
      .done        (done),
      .rd_data     (rd_data),
      .rd_valid    (rd_valid),
      .spi_cs_n    (spi_cs_n),
      .spi_sclk    (spi_sclk),
      .spi_io0_out (spi_io0_out),
      .spi_io0_oe  (spi_io0_oe),
      .spi_io0_in  (m_io0),
      .spi_io1_in  (m_io1)
   );

   int n_checks = 0;
   int n_err = 0;
   bit finished = 1'b0;

   function automatic logic [7:0] fdat(input logic [23:0] a);
      logic [7:0] m;
      m = a[7:0] * 8'd29;
      return m ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
   endfunction

   task automatic chk(input logic ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // behavioural flash
   logic        cur_dual = 1'b0;
   logic [39:0] cap = '0;
   int          rcnt = 0;
   int          cs_falls = 0;
   int          oe_bad = 0;
   int          sclk_cs_bad = 0;
   int          md;
   logic [23:0] ma;
   logic [7:0]  mb;

   always @(negedge spi_cs_n) begin
      rcnt = 0;
      cap  = '0;
      cs_falls++;
   end

   always @(posedge spi_sclk) begin
      if (spi_cs_n) sclk_cs_bad++;
      if (rcnt < (cur_dual ? 40 : 32)) begin
         cap = {cap[38:0], spi_io0_out};
         if (!spi_io0_oe) oe_bad++;
      end else if (cur_dual && spi_io0_oe) begin
         oe_bad++;
      end
      rcnt++;
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n && rcnt >= (cur_dual ? 40 : 32)) begin
         md = rcnt - (cur_dual ? 40 : 32);
         if (cur_dual) begin
            ma    = cap[31:8];
            mb    = fdat(24'(ma + 24'(md / 4)));
            m_io1 = mb[7 - 2 * (md % 4)];
            m_io0 = mb[6 - 2 * (md % 4)];
         end else begin
            ma    = cap[23:0];
            mb    = fdat(24'(ma + 24'(md / 8)));
            m_io1 = mb[7 - (md % 8)];
         end
      end
   end

   // byte capture and clock phase monitor, sampled mid-cycle
   logic [7:0] rx_q [64];
   int  nrx = 0;
   int  valid_stuck = 0;
   logic prev_valid = 1'b0;
   logic sclk_prev = 1'b0;
   int  run_len = 0;
   int  half_bad = 0;
   int  half_seen = 0;

   always @(negedge clk) begin
      if (rd_valid) begin
         if (nrx < 64) rx_q[nrx] = rd_data;
         nrx++;
         if (prev_valid) valid_stuck++;
      end
      prev_valid = rd_valid;
      if (spi_sclk != sclk_prev) begin
         if (sclk_prev) begin
            half_seen++;
            if (run_len != HALF) half_bad++;
         end
         run_len = 1;
      end else begin
         run_len++;
      end
      sclk_prev = spi_sclk;
   end

   task automatic run_txn(input logic dm, input logic [23:0] a, input int cnt, input int inject_at);
      int   cyc;
      logic got_done;
      logic [7:0] op_exp;
      string rq;
      @(negedge clk);
      cur_dual    = dm;
      nrx         = 0;
      cs_falls    = 0;
      oe_bad      = 0;
      valid_stuck = 0;
      start       = 1'b1;
      dual_mode   = dm;
      addr        = a;
      byte_count  = CNT_W'(cnt);
      @(negedge clk);
      start = 1'b0;
      if (cnt == 0) begin
         chk(done == 1'b1, "R9", "done after zero count", done, 1);
         chk(spi_cs_n == 1'b1 && busy == 1'b0, "R9", "cs/busy after zero count", {spi_cs_n, busy}, 2'b10);
         @(negedge clk);
         chk(done == 1'b0 && busy == 1'b0, "R9", "quiet after zero count", {done, busy}, 0);
         chk(cs_falls == 0, "R9", "chip select falls", cs_falls, 0);
         return;
      end
      chk(busy == 1'b1 && spi_cs_n == 1'b0, "R8", "busy and cs after start", {busy, spi_cs_n}, 2'b10);
      cyc      = 0;
      got_done = 1'b0;
      while (!got_done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (inject_at != 0 && cyc == inject_at) begin
            start      = 1'b1;
            addr       = a ^ 24'h5A5A5A;
            byte_count = CNT_W'(7);
            dual_mode  = ~dm;
         end else begin
            start = 1'b0;
         end
         if (done) begin
            got_done = 1'b1;
            chk(spi_cs_n == 1'b1 && busy == 1'b0, "R8", "release with done", {spi_cs_n, busy}, 2'b10);
         end
      end
      start = 1'b0;
      chk(got_done, "R8", "done seen", got_done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done width", done, 0);
      chk(cs_falls == 1, "R7", "chip select falls", cs_falls, 1);
      op_exp = dm ? 8'h3B : 8'h03;
      rq     = dm ? "R2" : "R1";
      chk((dm ? cap[39:32] : cap[31:24]) == op_exp, rq, "opcode", dm ? cap[39:32] : cap[31:24], op_exp);
      chk((dm ? cap[31:8] : cap[23:0]) == a, inject_at != 0 ? "R10" : "R3", "address",
          dm ? cap[31:8] : cap[23:0], a);
      if (dm) chk(cap[7:0] == 8'h00, "R2", "dummy byte", cap[7:0], 0);
      chk(oe_bad == 0, dm ? "R4" : "R1", "io0 drive enable errors", oe_bad, 0);
      chk(nrx == cnt, inject_at != 0 ? "R10" : "R6", "byte count", nrx, cnt);
      chk(valid_stuck == 0, "R6", "strobe width", valid_stuck, 0);
      for (int i = 0; i < cnt && i < 64; i++) begin
         chk(rx_q[i] == fdat(24'(a + 24'(i))), dm ? "R4" : "R5", "data byte",
             rx_q[i], fdat(24'(a + 24'(i))));
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [23:0] addrs [3];
      addrs[0] = 24'h000000;
      addrs[1] = 24'hFFFFFE;
      addrs[2] = 24'hA5C35A;
      repeat (5) @(negedge clk);
      chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R7", "reset pins", {spi_cs_n, spi_sclk}, 2'b10);
      chk(busy == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R8", "reset status",
          {busy, done, rd_valid}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         for (int ai = 0; ai < 3; ai++) begin
            for (int c = 0; c <= 5; c++) begin
               run_txn(m[0], addrs[ai], c, 0);
            end
         end
      end
      // start while busy must leave the running read untouched
      run_txn(1'b0, 24'h3C0F81, 3, 30);
      run_txn(1'b1, 24'h7E0102, 4, 50);
      chk(half_bad == 0 && half_seen > 0, "R11", "serial clock high phase", half_bad, 0);
      chk(sclk_cs_bad == 0, "R7", "clock edges while deselected", sclk_cs_bad, 0);
      finish_run();
   end

endmodule